// File: doc/BRIEF.md
# Soft-Ramped Digital Attenuator

This block is a per-channel volume stage for signed 24-bit audio samples. A programmed 8-bit level code sets the gain. Code 0xFF is unity, and every code below it takes away a further half decibel. Codes at 0x80 or below silence the channel. The gain actually applied never jumps to a new code. An internal active level walks toward the programmed code one step at a time, and holds each step for a fixed number of frames chosen by a 2-bit speed code. This keeps level changes free of clicks.

A soft-mute input replaces the programmed code with the mute code as the walk target. Releasing the mute sends the walk back to the programmed code, starting from wherever the level has reached. The programmed code is never altered by muting. Samples arrive with a valid strobe once per frame. Each scaled result leaves one clock later with its own strobe. Reset returns the active level to unity, and the level then walks to the programmed code.

Top module: `att_soft_ramp`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and out_sample is 0. After reset, the active level is 0xFF.
- R2: At active level 0xFF, out_sample equals the input sample exactly, including full-scale positive and negative values.
- R3: At active level L in 0x81..0xFE, let a = 0xFF - L, q = a / 12 and r = a % 12. The output is then (x*M[r] + 2^(15+q)) >>> (16+q), with arithmetic shift and the result kept to 24 bits. M[0..11] = 65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792.
- R4: At active level 0x80, the output is 0.
- R5: out_valid is high in exactly the cycle after each cycle in which in_valid is high. out_sample changes only in those cycles.
- R6: The active level changes only on frames. Each change is one code. Dwell D is 14, 7, 2 and 2 frames for speed codes 0, 1, 2 and 3. On a frame where the level equals the effective target, the dwell count clears. Otherwise the level steps when the count is at least D-1, and the count clears; if no step occurs, the count increments.
- R7: The effective target is 0x80 while smute is 1. Otherwise it is level_code, and any level_code below 0x80 is treated as 0x80.
- R8: Releasing smute before the level reaches 0x80 reverses the walk from the current level. The existing dwell count is kept.
- R9: A reset during operation returns the active level to 0xFF. After release, the level walks to the programmed code under R6.
- R10: After a mute and release, the level returns to whatever level_code holds at release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe marking a new frame sample |
| in_sample | input | 24 | Signed input sample |
| level_code | input | 8 | Programmed level, 0xFF unity, 0.5 dB per code |
| speed | input | 2 | Dwell selector per level code |
| smute | input | 1 | Soft mute request |
| out_valid | output | 1 | Strobe for the scaled sample |
| out_sample | output | 24 | Scaled signed sample |

## Verification
The active level and the dwell count are hidden, but the level shows up in the gain of the very next output. A stepping error therefore appears as a wrong sample one cycle after the frame on which it happens. This applies to a step that comes early, comes late, goes the wrong way or is skipped. A dwell count that is off by one is exposed within a single dwell period after any level change. A wrong mantissa, octave split or rounding shows on the first frame processed at the affected code.

// File: rtl/att_pkg.sv
package att_pkg;
  // Fraction bits of the gain mantissa; unity is 2**FRAC_W.
  localparam int FRAC_W = 16;
  localparam int MANT_W = FRAC_W + 1;
  // Codes per 6 dB octave at 0.5 dB per code.
  localparam int STEPS_PER_OCT = 12;
  localparam int FRAC_IDX_W = 4;

  // 2**FRAC_W * 10**(-k/40), rounded, for one octave.
  function automatic logic [MANT_W-1:0] oct_mantissa(input logic [FRAC_IDX_W-1:0] k);
    logic [MANT_W-1:0] m;
    case (k)
      4'd0:    m = 17'd65536;
      4'd1:    m = 17'd61870;
      4'd2:    m = 17'd58409;
      4'd3:    m = 17'd55142;
      4'd4:    m = 17'd52057;
      4'd5:    m = 17'd49145;
      4'd6:    m = 17'd46396;
      4'd7:    m = 17'd43801;
      4'd8:    m = 17'd41350;
      4'd9:    m = 17'd39037;
      4'd10:   m = 17'd36854;
      4'd11:   m = 17'd34792;
      default: m = 17'd65536;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/att_level_ramp.sv
module att_level_ramp #(
  parameter int LVL_W  = 8,
  parameter int DWELL0 = 14,
  parameter int DWELL1 = 7,
  parameter int DWELL2 = 2,
  parameter int DWELL3 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame,
  input  logic [LVL_W-1:0] target,
  input  logic [1:0]       speed,
  input  logic             smute,
  output logic [LVL_W-1:0] level
);
  localparam int DMAX01 = (DWELL0 > DWELL1) ? DWELL0 : DWELL1;
  localparam int DMAX23 = (DWELL2 > DWELL3) ? DWELL2 : DWELL3;
  localparam int DMAX   = (DMAX01 > DMAX23) ? DMAX01 : DMAX23;
  localparam int CNT_W  = $clog2(DMAX) + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = '1;
  localparam logic [LVL_W-1:0] LVL_MUTE = {1'b1, {(LVL_W-1){1'b0}}};

  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] eff;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (smute || (target <= LVL_MUTE)) eff = LVL_MUTE;
    else                               eff = target;
  end

  always_comb begin
    case (speed)
      2'd0:    lim = CNT_W'(DWELL0 - 1);
      2'd1:    lim = CNT_W'(DWELL1 - 1);
      2'd2:    lim = CNT_W'(DWELL2 - 1);
      default: lim = CNT_W'(DWELL3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= LVL_FULL;
      cnt_q <= '0;
    end else if (frame) begin
      if (lvl_q == eff) begin
        cnt_q <= '0;
      end else if (cnt_q >= lim) begin
        cnt_q <= '0;
        if (lvl_q < eff) lvl_q <= lvl_q + 1'b1;
        else             lvl_q <= lvl_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = lvl_q;

  // R6: no movement between frames
  assert_level_frame_only_R6: assert property (@(posedge clk) disable iff (rst)
    !frame |=> $stable(lvl_q));
  // R6: moves by a single code
  assert_single_code_step_R6: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ((lvl_q == $past(lvl_q) + 1'b1) || (lvl_q == $past(lvl_q) - 1'b1)));
  // R8: each step heads toward the effective target
  assert_step_toward_target_R8: assert property (@(posedge clk) disable iff (rst)
    frame && (lvl_q < eff) |=> (lvl_q >= $past(lvl_q)));
  // R7: level never drops below the mute code
  assert_level_floor_R7: assert property (@(posedge clk) disable iff (rst)
    lvl_q >= LVL_MUTE);
endmodule

// File: rtl/att_gain_stage.sv
module att_gain_stage
  import att_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [LVL_W-1:0]  level,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);
  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam logic [LVL_W-1:0] LVL_FULL = '1;
  localparam logic [LVL_W-1:0] LVL_MUTE = {1'b1, {(LVL_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] SAT_MAX = PROD_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_MIN = -(PROD_W'(64'sd1 <<< (DATA_W-1)));

  logic [LVL_W-1:0]         atten;
  logic [LVL_W-1:0]         oct;
  logic [FRAC_IDX_W-1:0]    frac;
  logic [MANT_W-1:0]        mant;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rnd_inc;
  logic signed [PROD_W-1:0] scaled;
  logic [DATA_W-1:0]        gained;

  always_comb begin
    atten   = LVL_FULL - level;
    oct     = atten / LVL_W'(STEPS_PER_OCT);
    frac    = FRAC_IDX_W'(atten % LVL_W'(STEPS_PER_OCT));
    mant    = oct_mantissa(frac);
    prod    = PROD_W'($signed(in_sample)) * $signed({1'b0, mant});
    rnd_inc = {{(PROD_W-1){1'b0}}, 1'b1} << (FRAC_W - 1 + int'(oct));
    scaled  = (prod + rnd_inc) >>> (FRAC_W + int'(oct));
    if (level <= LVL_MUTE)      gained = '0;
    else if (scaled > SAT_MAX)  gained = SAT_MAX[DATA_W-1:0];
    else if (scaled < SAT_MIN)  gained = SAT_MIN[DATA_W-1:0];
    else                        gained = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= gained;
    end
  end

  // R5: one strobe out per strobe in
  assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5: output held between frames
  assert_hold_between_frames_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sample)));
  // R4: mute code gives silence
  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (level <= LVL_MUTE) |=> (out_sample == '0));
  // R2: unity code passes the sample unchanged
  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && (level == LVL_FULL) |=> (out_sample == $past(in_sample)));
endmodule

// File: rtl/att_soft_ramp.sv
module att_soft_ramp #(
  parameter int DATA_W = 24,
  parameter int LVL_W  = 8,
  parameter int DWELL0 = 14,
  parameter int DWELL1 = 7,
  parameter int DWELL2 = 2,
  parameter int DWELL3 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [LVL_W-1:0]  level_code,
  input  logic [1:0]        speed,
  input  logic              smute,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample
);
  logic [LVL_W-1:0] act_level;

  att_level_ramp #(
    .LVL_W (LVL_W),
    .DWELL0(DWELL0),
    .DWELL1(DWELL1),
    .DWELL2(DWELL2),
    .DWELL3(DWELL3)
  ) u_ramp (
    .clk   (clk),
    .rst   (rst),
    .frame (in_valid),
    .target(level_code),
    .speed (speed),
    .smute (smute),
    .level (act_level)
  );

  att_gain_stage #(
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) u_gain (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .level     (act_level),
    .out_valid (out_valid),
    .out_sample(out_sample)
  );

  // R1: first cycle after reset shows no output
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && (out_sample == '0)));
endmodule

// File: tb/tb_att_soft_ramp.sv
module tb_att_soft_ramp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic [7:0]  level_code = 8'hFF;
  logic [1:0]  speed = 2'd0;
  logic        smute = 1'b0;
  logic        out_valid;
  logic [23:0] out_sample;

  int tests = 0;
  int fails = 0;
  int m_lvl = 255;
  int m_cnt = 0;

  always #4 clk = ~clk;

  att_soft_ramp dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .level_code(level_code), .speed(speed), .smute(smute),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic longint mtab(input int r);
    case (r)
      0: return 65536;  1: return 61870;  2: return 58409;  3: return 55142;
      4: return 52057;  5: return 49145;  6: return 46396;  7: return 43801;
      8: return 41350;  9: return 39037;  10: return 36854; default: return 34792;
    endcase
  endfunction

  function automatic logic [23:0] exp_out(input logic [23:0] x, input int lvl);
    longint p;
    int a, q, r;
    if (lvl <= 128) return 24'd0;
    a = 255 - lvl; q = a / 12; r = a % 12;
    p = longint'($signed(x)) * mtab(r);
    p = (p + (longint'(1) <<< (15 + q))) >>> (16 + q);
    return p[23:0];
  endfunction

  function automatic int dwell(input logic [1:0] s);
    case (s) 2'd0: return 14; 2'd1: return 7; default: return 2; endcase
  endfunction

  task automatic model_step();
    int eff;
    eff = (smute || level_code <= 8'h80) ? 128 : int'(level_code);
    if (m_lvl == eff) m_cnt = 0;
    else if (m_cnt >= dwell(speed) - 1) begin
      m_cnt = 0;
      m_lvl = (m_lvl < eff) ? m_lvl + 1 : m_lvl - 1;
    end else m_cnt = m_cnt + 1;
  endtask

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (model level %h)", tag, act, expv, m_lvl[7:0]);
    end
  endtask

  task automatic frame(input logic [23:0] x, input string tag, input int gap);
    logic [23:0] e;
    @(negedge clk);
    in_valid = 1'b1; in_sample = x;
    e = exp_out(x, m_lvl);
    model_step();
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_sample === e, tag, out_sample, e);
    if (gap > 0) begin
      repeat (gap) @(negedge clk);
      check(out_valid === 1'b0 && out_sample === e, "R5 hold", out_sample, e);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_lvl = 255; m_cnt = 0;
    check(out_valid === 1'b0 && out_sample === 24'd0, "R1 reset", out_sample, 24'd0);
  endtask

  function automatic logic [23:0] rnd();
    return 24'($urandom);
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_sample === 24'd0, "R1 during reset", out_sample, 24'd0);
    do_reset();
    // R2 unity, directed extremes then random
    frame(24'h7FFFFF, "R2 unity max", 1);
    frame(24'h800000, "R2 unity min", 0);
    frame(24'h000001, "R2 unity one", 0);
    for (int i = 0; i < 10; i++) frame(rnd(), "R2 unity rnd", i % 2);
    // R6 dwell at each speed, short walks downward
    speed = 2'd0; level_code = 8'hFC;
    for (int i = 0; i < 50; i++) frame(rnd(), "R6 dwell speed0", 0);
    speed = 2'd1; level_code = 8'hF0;
    for (int i = 0; i < 90; i++) frame(rnd(), "R6 dwell speed1", 0);
    speed = 2'd2; level_code = 8'hC0;
    for (int i = 0; i < 80; i++) frame(rnd(), "R6 dwell speed2", 0);
    // R3 gain law across a wide walk at speed 3
    speed = 2'd3; level_code = 8'h81;
    for (int i = 0; i < 160; i++) frame(rnd(), "R3 gain law", 0);
    frame(24'h7FFFFF, "R3 deepest max", 0);
    frame(24'h800000, "R3 deepest min", 0);
    // R7 soft mute to silence, then R4 mute output
    smute = 1'b1;
    for (int i = 0; i < 4; i++) frame(rnd(), "R7 mute walk", 0);
    for (int i = 0; i < 6; i++) frame(24'h7FFFFF, "R4 mute zero", 1);
    // R7 target below mute code stays silent
    smute = 1'b0; level_code = 8'h10;
    for (int i = 0; i < 10; i++) frame(rnd(), "R7 low target", 0);
    // R10 target changed while muted, restored on release
    smute = 1'b1; level_code = 8'hD0;
    for (int i = 0; i < 20; i++) frame(rnd(), "R10 muted hold", 0);
    smute = 1'b0;
    for (int i = 0; i < 220; i++) frame(rnd(), "R10 return", 0);
    // R8 reversal mid ramp at speed 0
    speed = 2'd0; smute = 1'b1;
    for (int i = 0; i < 100; i++) frame(rnd(), "R8 mute partial", 0);
    smute = 1'b0;
    for (int i = 0; i < 120; i++) frame(rnd(), "R8 reverse", 0);
    // R9 reset during operation
    speed = 2'd3; level_code = 8'hA0;
    for (int i = 0; i < 5; i++) frame(rnd(), "R9 before", 0);
    do_reset();
    for (int i = 0; i < 200; i++) frame(rnd(), "R9 walk", 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 49) == 0) level_code = 8'($urandom);
      if ($urandom_range(0, 79) == 0) smute = ~smute;
      if ($urandom_range(0, 99) == 0) speed = 2'($urandom);
      frame(rnd(), "R3 random", (i % 7 == 0) ? 1 : 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule